// File: doc/BRIEF.md
# Circular-Buffer FIR Multiply-Accumulate Engine

This block is a sample-driven FIR filter. Each accepted input sample is stored in a delay-line memory. The engine then walks every tap, doing one signed multiply-accumulate per clock. It pairs a stored sample with a coefficient from a separate coefficient memory, so both operands are read in the same cycle. Both memories are addressed by modulo address generators. These add a fixed step to the pointer after each access and wrap it back into the buffer, so the delay line works as a ring and no samples are ever moved.

Only the last tap adds the rounding constant. The accumulator has guard bits above the full product width. If the final sum does not fit the output word, the result is clamped to the largest positive or negative output value. The result is taken from the upper part of the accumulator and presented with a single-cycle valid strobe. After reset, the engine first writes zeros into every delay-line location, one per cycle, before it takes any sample. The tap count and the coefficient set are parameters.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `out_valid` and `out_sample` are 0. For TAPS cycles after reset release the engine clears every delay-line location to zero, one per cycle. Strobes during this phase are ignored, and the first filtered result sees zero history.
- R2: A strobe sampled high at rising edge E while idle is accepted. `out_valid` is then high for exactly the one cycle after edge E+TAPS+1. `out_sample` = sat(round(sum over k of c[k]·x[n−TAPS+1+k])), where x[n] is the new sample, c[k] is coefficient k (bits k·COEF_W upward of `COEF_VEC`), and c[TAPS−1] weights the newest sample.
- R3: `out_valid` is never high for two cycles in a row. `out_sample` holds its value between strobes.
- R4: Rounding happens once. The sum of products, in units of 2^−(COEF_W−1) of an output LSB, has 2^(COEF_W−2) added, and is then truncated toward minus infinity to the output word.
- R5: If the rounded result is above 2^(SAMPLE_W−1)−1 it becomes 2^(SAMPLE_W−1)−1 (16'h7FFF by default). If it is below −2^(SAMPLE_W−1) it becomes −2^(SAMPLE_W−1) (16'h8000).
- R6: A strobe that arrives while the engine is computing or finishing a result is ignored. It produces no output pulse and is not written to the delay line.
- R7: Both pointers advance by one modulo TAPS, so the filter keeps using the most recent TAPS samples across any number of inputs.
- R8: Saturation depends only on the final sum. Partial sums that go beyond the output range but come back into it give the exact rounded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New-sample strobe |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_sample | output | SAMPLE_W | Signed filtered result |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
A strobe captured at edge E has its result due just after edge E+TAPS+1. One cycle for the write, TAPS cycles of multiply-accumulate and one cycle for the saturating output register add up to that figure. The bench drives each strobe at a falling edge and samples at every following falling edge. It requires `out_valid` low through edge E+TAPS, then high with the expected value, then low again with the value held. Strobes that must be ignored are placed inside that window, including the final cycle. The delay-line clearing is checked by resetting in mid-run and comparing the first result with a zero-history model.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_MAC   = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_e;

endpackage

// File: rtl/fir_modulo_agen.sv
module fir_modulo_agen #(
    parameter int LEN    = 15,
    parameter int MODIFY = 1,
    parameter int AW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_d, ptr_q;

    generate
        if ((1 << AW) == LEN) begin : g_pow2
            always_comb begin
                ptr_d = ptr_q;
                if (step) ptr_d = ptr_q + AW'(MODIFY);
            end
        end else begin : g_mod
            localparam logic [AW:0] LEN_V = (AW+1)'(LEN);
            localparam logic [AW:0] MOD_V = (AW+1)'(MODIFY);
            logic [AW:0] sum;
            always_comb begin
                sum   = {1'b0, ptr_q} + MOD_V;
                ptr_d = ptr_q;
                if (step) begin
                    if (sum >= LEN_V) ptr_d = AW'(sum - LEN_V);
                    else              ptr_d = sum[AW-1:0];
                end
            end
            // R7
            ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                {1'b0, ptr_q} < LEN_V);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/fir_delay_ram.sv
module fir_delay_ram #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
    parameter int DEPTH = 15,
    parameter int AW    = 4,
    parameter int CW    = 24,
    parameter logic [DEPTH*CW-1:0] COEF_VEC = '0
) (
    input  logic [AW-1:0] addr,
    output logic [CW-1:0] coef
);
    localparam int WORDS = 1 << AW;
    logic [CW-1:0] tbl [WORDS];

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_word
            if (g < DEPTH) begin : g_used
                assign tbl[g] = COEF_VEC[g*CW +: CW];
            end else begin : g_pad
                assign tbl[g] = '0;
            end
        end
    endgenerate

    assign coef = tbl[addr];
endmodule

// File: rtl/fir_mac_acc.sv
module fir_mac_acc #(
    parameter int SW = 16,
    parameter int CW = 24,
    parameter int GW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic                 rnd,
    input  logic signed [SW-1:0] a,
    input  logic signed [CW-1:0] b,
    output logic        [SW-1:0] result
);
    localparam int PROD_W  = SW + CW;
    localparam int ACC_W   = PROD_W + GW;
    localparam int OUT_LSB = CW - 1;
    localparam int TOP_W   = ACC_W - (OUT_LSB + SW - 1);
    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (OUT_LSB - 1);

    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [TOP_W-1:0] top_bits;
    logic             fits;

    always_comb begin
        prod  = a * b;
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = acc_q + {{GW{prod[PROD_W-1]}}, prod} + (rnd ? HALF : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    always_comb begin
        top_bits = acc_q[ACC_W-1 -: TOP_W];
        fits     = (&top_bits) | ~(|top_bits);
        if (fits)                result = acc_q[OUT_LSB +: SW];
        else if (acc_q[ACC_W-1]) result = {1'b1, {(SW-1){1'b0}}};
        else                     result = {1'b0, {(SW-1){1'b1}}};
    end

    // R2
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
    parameter int TAPS     = 15,
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 24,
    parameter int GUARD_W  = 8,
    parameter logic [TAPS*COEF_W-1:0] COEF_VEC =
        {TAPS{COEF_W'(1) << (COEF_W - 5)}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_valid
);
    import fir_mac_pkg::*;

    localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam logic [AW-1:0] LAST_CNT = AW'(TAPS - 1);

    typedef struct packed {
        eng_state_e          st;
        logic [AW-1:0]       cnt;
        logic [SAMPLE_W-1:0] out;
        logic                vld;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic                d_step, c_step, dl_we;
    logic [SAMPLE_W-1:0] dl_wdata, dl_rdata, mac_result;
    logic [AW-1:0]       d_ptr, c_ptr;
    logic [COEF_W-1:0]   coef;
    logic                mac_clr, mac_en, mac_rnd;

    fir_modulo_agen #(.LEN(TAPS), .MODIFY(1), .AW(AW)) u_dline_agen (
        .clk(clk), .rst_n(rst_n), .step(d_step), .ptr(d_ptr)
    );

    fir_modulo_agen #(.LEN(TAPS), .MODIFY(1), .AW(AW)) u_coef_agen (
        .clk(clk), .rst_n(rst_n), .step(c_step), .ptr(c_ptr)
    );

    fir_delay_ram #(.AW(AW), .DW(SAMPLE_W)) u_dline (
        .clk(clk), .we(dl_we), .waddr(d_ptr), .wdata(dl_wdata),
        .raddr(d_ptr), .rdata(dl_rdata)
    );

    fir_coef_rom #(.DEPTH(TAPS), .AW(AW), .CW(COEF_W), .COEF_VEC(COEF_VEC)) u_coefs (
        .addr(c_ptr), .coef(coef)
    );

    fir_mac_acc #(.SW(SAMPLE_W), .CW(COEF_W), .GW(GUARD_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clear(mac_clr), .en(mac_en), .rnd(mac_rnd),
        .a(dl_rdata), .b(coef), .result(mac_result)
    );

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        d_step   = 1'b0;
        c_step   = 1'b0;
        dl_we    = 1'b0;
        dl_wdata = '0;
        mac_clr  = 1'b0;
        mac_en   = 1'b0;
        mac_rnd  = 1'b0;
        case (r_q.st)
            ST_CLEAR: begin
                dl_we  = 1'b1;
                d_step = 1'b1;
                if (r_q.cnt == '0) r_d.st = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_IDLE: begin
                if (in_valid) begin
                    dl_we    = 1'b1;
                    dl_wdata = in_sample;
                    d_step   = 1'b1;
                    mac_clr  = 1'b1;
                    r_d.cnt  = LAST_CNT;
                    r_d.st   = ST_MAC;
                end
            end
            ST_MAC: begin
                mac_en = 1'b1;
                d_step = 1'b1;
                c_step = 1'b1;
                if (r_q.cnt == '0) begin
                    mac_rnd = 1'b1;
                    r_d.st  = ST_DONE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d.out = mac_result;
                r_d.vld = 1'b1;
                r_d.st  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_CLEAR;
            r_q.cnt <= LAST_CNT;
            r_q.out <= '0;
            r_q.vld <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_sample = r_q.out;
    assign out_valid  = r_q.vld;

    int lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                            lat_q <= 0;
        else if (r_q.st == ST_IDLE && in_valid) lat_q <= 1;
        else if (out_valid)                    lat_q <= 0;
        else if (lat_q != 0)                   lat_q <= lat_q + 1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_q == TAPS + 2));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    // R6
    no_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MAC || r_q.st == ST_DONE) |-> !dl_we);
endmodule

// File: tb/fir_mac_engine_tb_top.sv
`timescale 1ns/1ps
module fir_mac_engine_tb_top;
    localparam int TAPS = 15;
    localparam int SW   = 16;
    localparam int CW   = 24;
    localparam int CF [TAPS] = '{3000000, -2000000, 4000000, 1500000, -3500000,
                                 2500000, 5000000, 8000000, -6000000, 1000000,
                                 2000000, -1000000, 7000000, 300000, 4194304};
    localparam int STIM [24] = '{100, -200, 32000, -32000, 5, 0, 12345, -9876,
                                 777, -1, 20000, -20000, 3, 4096, -4096, 16384,
                                 -16384, 250, -250, 31000, -31000, 9, -9, 1};

    function automatic logic [TAPS*CW-1:0] pack_coefs();
        logic [TAPS*CW-1:0] v;
        v = '0;
        for (int k = 0; k < TAPS; k++) v[k*CW +: CW] = CW'(CF[k]);
        return v;
    endfunction
    localparam logic [TAPS*CW-1:0] COEFS = pack_coefs();

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic [SW-1:0] out_sample;
    logic          out_valid;

    fir_mac_engine #(.TAPS(TAPS), .SAMPLE_W(SW), .COEF_W(CW), .GUARD_W(8),
                     .COEF_VEC(COEFS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_sample(out_sample), .out_valid(out_valid)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int hist [TAPS];
    bit done = 1'b0;

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic int model();
        longint acc = 0;
        for (int k = 0; k < TAPS; k++) acc += longint'(hist[k]) * longint'(CF[k]);
        acc += longint'(1) << (CW - 2);
        acc = acc >>> (CW - 1);
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    function automatic void push(int x);
        for (int k = 0; k < TAPS - 1; k++) hist[k] = hist[k+1];
        hist[TAPS-1] = x;
    endfunction

    function automatic void clear_hist();
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
    endfunction

    int last_out;

    // Strobe a sample, optionally poke a second strobe at window step poke_at.
    task automatic send(int x, string req, int poke_at, int poke_val);
        int  exp;
        bit  early;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = SW'(x);
        @(negedge clk);
        in_valid = 1'b0;
        push(x);
        exp   = model();
        early = 1'b0;
        for (int j = 1; j <= TAPS + 1; j++) begin
            if (poke_at == j) begin
                in_valid  = 1'b1;
                in_sample = SW'(poke_val);
            end
            @(negedge clk);
            in_valid = 1'b0;
            if (j <= TAPS) begin
                if (out_valid) early = 1'b1;
            end else begin
                check_eq({req, " valid at due cycle"}, int'(out_valid), 1);
                check_eq({req, " result"}, int'($signed(out_sample)), exp);
            end
        end
        check_eq({req, " no early valid (R2)"}, int'(early), 0);
        @(negedge clk);
        check_eq("R3 pulse one cycle", int'(out_valid), 0);
        check_eq("R3 value held", int'($signed(out_sample)), exp);
        last_out = exp;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset valid", int'(out_valid), 0);
        check_eq("R1 reset sample", int'(out_sample), 0);
        rst_n = 1'b1;
        clear_hist();
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        bit seen;
        clear_hist();
        do_reset();
        // R1/R6: strobe during the clearing phase is ignored
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = SW'(30000);
        @(negedge clk);
        in_valid = 1'b0;
        seen = 1'b0;
        for (int j = 0; j < 2 * TAPS + 4; j++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        check_eq("R1 strobe in clear phase ignored", int'(seen), 0);

        // R2/R7: vector table, longer than the ring so pointers wrap
        for (int i = 0; i < 24; i++) send(STIM[i], "R2 R7 table", 0, 0);

        // R5: positive and negative saturation
        for (int i = 0; i < TAPS; i++) send(32767, "R5 high", 0, 0);
        check_eq("R5 clamp high", last_out, 32767);
        for (int i = 0; i < TAPS; i++) send(-32768, "R5 low", 0, 0);
        check_eq("R5 clamp low", last_out, -32768);

        // R8: partial sums exceed range, final result fits
        for (int i = 0; i < 9; i++) send(32767, "R8 ramp", 0, 0);
        send(-32768, "R8 mix", 0, 0);
        send(-32768, "R8 mix", 0, 0);
        send(32767, "R8 mix", 0, 0);
        send(-32768, "R8 mix", 0, 0);
        send(-32768, "R8 mix", 0, 0);
        send(-32768, "R8 final", 0, 0);
        check_eq("R8 not saturated", int'(last_out > -32768 && last_out < 32767), 1);

        // R6: strobes while busy (mid-loop and in the finishing cycle)
        send(1000, "R6 poke mid", 5, 20000);
        send(-700, "R6 poke done", TAPS + 1, 15000);
        send(50, "R6 history excludes pokes", 0, 0);

        // R1/R4: reset clears history; rounding on newest tap c=2^22
        do_reset();
        repeat (2 * TAPS) @(negedge clk);
        send(3, "R1 R4 after reset", 0, 0);
        check_eq("R4 round 3 -> 2", last_out, 2);
        do_reset();
        repeat (2 * TAPS) @(negedge clk);
        send(-3, "R1 R4 after reset", 0, 0);
        check_eq("R4 round -3 -> -1", last_out, -1);

        finish_run();
    end
endmodule